// File: doc/BRIEF.md
# Converter Serial Readout Port with Data-Ready Flag

This block is the digital side of a converter's serial port. The conversion core hands it a finished result with a one-cycle strobe. The block keeps that result and raises an internal "unread" flag. An external SPI master reads the result out whenever it selects the device. The same serial line carries a data-ready level when select goes low. It then carries the result, most significant bit first, in SPI mode 1 (clock idles low, data changes on the rising edge, data is sampled on the falling edge). While the master reads, it shifts a 16-bit configuration word in on the input line. That word updates the configuration register, which is also passed to the core.

The output pad is modelled as three signals: a data value, an output enable, and a weak pull-up request. Chip select, serial clock and serial input are asynchronous to the system clock. All three go through a synchroniser and edge detection before any logic uses them. A result that the core delivers while a read is in progress never disturbs the bits being shifted. It waits for the next selection.

Top module: `adc_spi_port`

## Requirements
- R1: After reset the configuration output is 16'h058B, the held result is 16'h0000, miso_oe is 0 and pullup_en is 1.
- R2: While the synchronised chip select is high, miso_oe stays 0, including when a result arrives. pullup_en is 1 only while miso_oe is 0 and configuration bit 3 is 1.
- R3: On a falling chip select, the block enables the output. Before the first serial clock edge the output level is 0 if an unread result is pending and 1 if none is pending.
- R4: The result is loaded at the chip select fall. It is presented MSB first, and bit k (counted from the MSB) appears after the (k+1)-th rising serial clock edge.
- R5: With no unread result pending, a read returns the most recently delivered result again.
- R6: A result delivered while chip select is low does not change the bits of the current read. The result is held, and the next read shows a pending level (0) and returns it.
- R7: The pending flag is set by conv_done and cleared by the chip select fall that captures the result. If conv_done coincides with that capture, the read returns the older result and the flag stays set.
- R8: Input bits are sampled on falling serial clock edges, MSB first. After the 16th falling edge of a selection, those 16 bits replace the configuration register. A selection with fewer than 16 falling edges leaves the register unchanged, and bits after the 16th are ignored.
- R9: With configuration bit 3 written to 0, pullup_en is 0 while deselected, so the line is fully released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| sclk | input | 1 | Serial clock, idles low, asynchronous |
| mosi | input | 1 | Serial data into the block |
| conv_done | input | 1 | One-cycle strobe: a new result is on conv_data |
| conv_data | input | 16 | Result from the conversion core |
| miso_o | output | 1 | Serial output value (data-ready level, then result bits) |
| miso_oe | output | 1 | Output enable for the serial output pad |
| pullup_en | output | 1 | Weak pull-up request while the output is released |
| cfg_o | output | 16 | Current configuration register |

## Verification
The hardest situation to reach is a conv_done strobe that lands in exactly the clock cycle where the synchronised chip select fall captures the held result. The outcome depends on the ordering between the capture and the flag update. The bench drives chip select low on a falling clock edge and counts the two synchroniser stages. It then raises conv_done in the one cycle whose rising edge performs the capture. It checks that this read returns the older value and that the following read reports pending and returns the new one. A second hand-timed case delivers a result partway through the shift.

// File: rtl/adc_spi_pkg.sv
package adc_spi_pkg;
  localparam int DATA_W      = 16;
  localparam int SYNC_STAGES = 2;
  localparam int PU_BIT      = 3;
  localparam logic [DATA_W-1:0] CFG_RESET = 16'h058B;

  // Level shown on the line at selection: low means an unread result waits.
  function automatic logic ready_level(input logic pending);
    return ~pending;
  endfunction

  // Weak pull-up request: only while released, and only when enabled.
  function automatic logic pull_request(input logic [DATA_W-1:0] cfg, input logic driving);
    return cfg[PU_BIT] & ~driving;
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[g] <= RST_VAL;
          else        stg[g] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[g] <= RST_VAL;
          else        stg[g] <= stg[g-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/result_hold.sv
module result_hold #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         conv_done,
  input  logic [W-1:0] conv_data,
  input  logic         capture,
  output logic [W-1:0] latest,
  output logic         pending
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latest  <= '0;
      pending <= 1'b0;
    end else begin
      if (conv_done) latest <= conv_data;
      if (conv_done)    pending <= 1'b1;
      else if (capture) pending <= 1'b0;
    end
  end

  a_r5_pending_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> pending);
  a_r7_clear_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
    capture && !conv_done |=> !pending);
  a_r6_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> $stable(latest));
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
  import adc_spi_pkg::*;
#(
  parameter int W = 16,
  parameter logic [W-1:0] CFG_RST = 16'h058B
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_fall,
  input  logic         cs_rise,
  input  logic         sclk_rise,
  input  logic         sclk_fall,
  input  logic         mosi_s,
  input  logic [W-1:0] load_val,
  input  logic         pend_in,
  output logic         miso_q,
  output logic         oe_q,
  output logic [W-1:0] cfg,
  output logic         cfg_wr
);
  localparam int CNT_W = $clog2(W) + 1;

  logic [W-1:0]     shreg;
  logic [W-1:0]     inbuf;
  logic [CNT_W-1:0] bitcnt;
  logic             shift_out;
  logic             shift_in;

  assign shift_out = oe_q & sclk_rise;
  assign shift_in  = oe_q & sclk_fall & (bitcnt < CNT_W'(W));
  assign cfg_wr    = shift_in & (bitcnt == CNT_W'(W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      inbuf  <= '0;
      bitcnt <= '0;
      miso_q <= 1'b1;
      oe_q   <= 1'b0;
      cfg    <= CFG_RST;
    end else begin
      if (cs_fall) begin
        shreg  <= load_val;
        miso_q <= ready_level(pend_in);
        oe_q   <= 1'b1;
        bitcnt <= '0;
        inbuf  <= '0;
      end else begin
        if (cs_rise) oe_q <= 1'b0;
        if (shift_out) begin
          miso_q <= shreg[W-1];
          shreg  <= {shreg[W-2:0], 1'b0};
        end
        if (shift_in) begin
          inbuf  <= {inbuf[W-2:0], mosi_s};
          bitcnt <= bitcnt + 1'b1;
        end
        if (cfg_wr) cfg <= {inbuf[W-2:0], mosi_s};
      end
    end
  end

  a_r3_ready_level: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (miso_q == !$past(pend_in)) && oe_q);
  a_r6_shift_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_fall && !shift_out |=> $stable(shreg));
  a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(cfg));
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= CNT_W'(W));
endmodule

// File: rtl/adc_spi_port.sv
module adc_spi_port
  import adc_spi_pkg::*;
#(
  parameter int W      = DATA_W,
  parameter int STAGES = SYNC_STAGES,
  parameter logic [W-1:0] CFG_RST = CFG_RESET
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         sclk,
  input  logic         mosi,
  input  logic         conv_done,
  input  logic [W-1:0] conv_data,
  output logic         miso_o,
  output logic         miso_oe,
  output logic         pullup_en,
  output logic [W-1:0] cfg_o
);
  logic [2:0] pins_s;
  logic       cs_s, sclk_s, mosi_s;
  logic       cs_d, sclk_d;
  logic       cs_fall, cs_rise, sclk_rise, sclk_fall;
  logic [W-1:0] latest;
  logic       pending;
  logic       cfg_wr;

  spi_sync #(.W(3), .STAGES(STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, mosi}), .q(pins_s));

  assign cs_s   = pins_s[2];
  assign sclk_s = pins_s[1];
  assign mosi_s = pins_s[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d   <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      cs_d   <= cs_s;
      sclk_d <= sclk_s;
    end
  end

  assign cs_fall   = cs_d & ~cs_s;
  assign cs_rise   = ~cs_d & cs_s;
  assign sclk_rise = ~sclk_d & sclk_s;
  assign sclk_fall = sclk_d & ~sclk_s;

  result_hold #(.W(W)) u_hold (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_data(conv_data),
    .capture(cs_fall), .latest(latest), .pending(pending));

  spi_shifter #(.W(W), .CFG_RST(CFG_RST)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi_s(mosi_s),
    .load_val(latest), .pend_in(pending), .miso_q(miso_o), .oe_q(miso_oe),
    .cfg(cfg_o), .cfg_wr(cfg_wr));

  assign pullup_en = pull_request(cfg_o, miso_oe);

  a_r2_quiet_when_high: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s && cs_d |-> !miso_oe);
  a_r2_pull_only_released: assert property (@(posedge clk) disable iff (!rst_n)
    pullup_en |-> !miso_oe);
  a_r7_capture_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall && pending && !conv_done |=> !pending);
endmodule

// File: tb/tb_adc_spi_port.sv
module tb_adc_spi_port;
  localparam int HALF = 8;
  localparam int NV   = 8;
  // {conv_en, conv_val, mosi_word, nbits, exp_ready, exp_data, exp_cfg, exp_pull}
  localparam logic [74:0] VEC [NV] = '{
    {1'b0, 16'h0000, 16'h058B, 8'd16, 1'b1, 16'h0000, 16'h058B, 1'b1},
    {1'b1, 16'h1234, 16'h058B, 8'd16, 1'b0, 16'h1234, 16'h058B, 1'b1},
    {1'b0, 16'h0000, 16'h0583, 8'd16, 1'b1, 16'h1234, 16'h0583, 1'b0},
    {1'b1, 16'hABCD, 16'h058B, 8'd16, 1'b0, 16'hABCD, 16'h058B, 1'b1},
    {1'b1, 16'h8001, 16'h0000, 8'd8,  1'b0, 16'h8001, 16'h058B, 1'b1},
    {1'b0, 16'h0000, 16'h058B, 8'd32, 1'b1, 16'h8001, 16'h058B, 1'b1},
    {1'b0, 16'h0000, 16'h0AB3, 8'd16, 1'b1, 16'h8001, 16'h0AB3, 1'b0},
    {1'b0, 16'h0000, 16'h058B, 8'd16, 1'b1, 16'h8001, 16'h058B, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0, conv_done = 1'b0;
  logic [15:0] conv_data = '0;
  logic miso_o, miso_oe, pullup_en;
  logic [15:0] cfg_o;
  int nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  adc_spi_port dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .conv_done(conv_done), .conv_data(conv_data), .miso_o(miso_o), .miso_oe(miso_oe),
    .pullup_en(pullup_en), .cfg_o(cfg_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_conv(input logic [15:0] v);
    conv_data = v; conv_done = 1'b1;
    @(negedge clk); conv_done = 1'b0;
  endtask

  // hook 0: none; 1: strobe in the capture cycle; 2: strobe after four bits
  task automatic xfer(input logic [15:0] w, input int nbits, input int hook,
                      input logic [15:0] hv, output logic rdy, output logic [31:0] rd);
    rd = '0;
    @(negedge clk); cs_n = 1'b0;
    if (hook == 1) begin
      @(negedge clk); @(negedge clk);
      pulse_conv(hv);
      repeat (HALF - 3) @(negedge clk);
    end else repeat (HALF) @(negedge clk);
    rdy = miso_o;
    chk("R3 output enabled after select", {31'd0, miso_oe}, 32'd1);
    for (int i = 0; i < nbits; i++) begin
      if (hook == 2 && i == 4) pulse_conv(hv);
      sclk = 1'b1; mosi = (i < 16) ? w[15 - i] : 1'b0;
      repeat (HALF) @(negedge clk);
      rd = {rd[30:0], miso_o};
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  function automatic logic [31:0] top_bits(input logic [31:0] rd, input int n);
    if (n >= 16) return (rd >> (n - 16)) & 32'hFFFF;
    return rd & ((32'd1 << n) - 1);
  endfunction

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic rdy;
    logic [31:0] rd;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 cfg reset", {16'd0, cfg_o}, 32'h058B);
    chk("R1 oe reset", {31'd0, miso_oe}, 32'd0);
    chk("R1 pullup reset", {31'd0, pullup_en}, 32'd1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [74:0] e;
      int n;
      e = VEC[v];
      n = int'(e[41:34]);
      if (e[74]) pulse_conv(e[73:58]);
      xfer(e[57:42], n, 0, 16'h0, rdy, rd);
      chk("R3/R5 ready level", {31'd0, rdy}, {31'd0, e[33]});
      chk("R4/R5 read data", top_bits(rd, n),
          (n >= 16) ? {16'd0, e[32:17]} : ({16'd0, e[32:17]} >> (16 - n)));
      chk("R8 config value", {16'd0, cfg_o}, {16'd0, e[16:1]});
      chk("R2/R9 pullup when released", {31'd0, pullup_en}, {31'd0, e[0]});
    end

    // R2: a result arriving while deselected gives no pulse on the line
    pulse_conv(16'h5A5A);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R2 no enable while deselected", {31'd0, miso_oe}, 32'd0);
    end

    // R6: a new result mid-read leaves the current bits unchanged
    xfer(16'h058B, 16, 2, 16'hC3C3, rdy, rd);
    chk("R6 ready before mid-read result", {31'd0, rdy}, 32'd0);
    chk("R6 current read unchanged", rd & 32'hFFFF, 32'h5A5A);
    xfer(16'h058B, 16, 0, 16'h0, rdy, rd);
    chk("R6 deferred result pending", {31'd0, rdy}, 32'd0);
    chk("R6 deferred result read", rd & 32'hFFFF, 32'hC3C3);

    // R7: strobe in the very capture cycle
    xfer(16'h058B, 16, 1, 16'h7E7E, rdy, rd);
    chk("R7 nothing pending at fall", {31'd0, rdy}, 32'd1);
    chk("R7 older result read", rd & 32'hFFFF, 32'hC3C3);
    xfer(16'h058B, 16, 0, 16'h0, rdy, rd);
    chk("R7 flag kept set", {31'd0, rdy}, 32'd0);
    chk("R7 coincident result read", rd & 32'hFFFF, 32'h7E7E);
    xfer(16'h058B, 16, 0, 16'h0, rdy, rd);
    chk("R5 repeat after clear", {31'd0, rdy}, 32'd1);
    chk("R5 repeat data", rd & 32'hFFFF, 32'h7E7E);

    finish_run();
  end
endmodule